// File: doc/BRIEF.md
# Register-Mapped SPI Controller

This block is an 8-bit SPI port that a processor drives through three byte-wide registers on a small synchronous register bus: a control register, a status register and a data register. In master mode a write to the data register starts a transfer. The block divides the system clock to make SCK, shifts the byte out on MOSI and shifts in the byte from MISO. In slave mode it passes the external SCK, MOSI and active-low select through two-flop synchronisers. It shifts only while it is selected, and it drives MISO from a byte that software loaded earlier.

Software learns that a transfer has finished from a completion flag, which can also raise an interrupt. A data write during a transfer is discarded and sets a collision flag. Both flags clear when software reads status while a flag is set and then reads or writes the data register. In master mode, an external device that pulls the select input low takes the block back to slave mode and sets the completion flag.

The register bus has no back-pressure: reads return data in the same cycle, and writes are accepted or ignored in the cycle they are presented. Software must not write the data register while a transfer is running; the collision flag reports any such write, and the write is not stalled.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control, status and data registers read 0x00, irq is low, sck_out is low and both output enables are low.
- R2: Register addresses are 0 control, 1 status, 2 data. Control bits 7..0 are interrupt enable, SPI enable, LSB-first, master, clock polarity, clock phase and rate[1:0]. In status, bit 7 is the completion flag, bit 6 is the collision flag and bit 0 is the double-speed bit. Status bits 5..1 always read 0.
- R3: With LSB-first=0 the byte goes out and comes in MSB first; with LSB-first=1 it goes LSB first. Bits received by the master appear in the data register.
- R4: SCK idles at the polarity bit and returns there after the transfer. With phase=0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase=1, data is changed on the leading edge and sampled on the trailing edge.
- R5: In master mode each SCK half-period lasts 2, 8, 32 or 64 system clocks for rate 00, 01, 10 or 11; the double-speed bit halves it to 1, 4, 16 or 32.
- R6: The completion flag sets after the eighth bit. irq is high when the flag and interrupt enable are both 1. A pulse on irq_ack clears the flag.
- R7: Reading status while either flag is set, followed by a read or write of the data register, clears both flags. A data-register access with no such status read first leaves the flags set.
- R8: A data-register write while a master transfer is running sets the collision flag and does not change the byte being sent.
- R9: In master mode with SPI enabled, a low select input clears the master bit and sets the completion flag.
- R10: In slave mode, with SCK at most a quarter of the system clock, the block receives the MOSI byte into the data register and sends its loaded byte on MISO in each of the four clock modes.
- R11: A slave whose select input is high ignores SCK toggles: no flag is set and no bits shift.
- R12: A data-register write while SPI enable is 0 has no effect, and raises no collision flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives flag-clear side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck_in | input | 1 | SCK from an external master |
| mosi_in | input | 1 | MOSI from an external master |
| ss_n_in | input | 1 | Active-low select input |
| miso_in | input | 1 | MISO from an external slave |
| sck_out | output | 1 | Generated SCK |
| sck_out_en | output | 1 | Output enable for sck_out (master mode) |
| mosi_out | output | 1 | MOSI driven in master mode |
| mosi_out_en | output | 1 | Output enable for mosi_out |
| miso_out | output | 1 | MISO driven in slave mode |
| miso_out_en | output | 1 | Output enable for miso_out (slave and selected) |

## Verification
The assertions assume that reg_rd and reg_wr are never high together. They also assume that, in slave mode, each level of the external SCK is held for at least four system clocks, so the synchronised edge detector sees every edge. The select input is assumed to change only while SCK is idle, and it is assumed high in master mode except when a mode fault is intended. The bench drives slave SCK with eight system clocks per level and moves select only while SCK is idle. In master tests it holds select high, and it pulls select low only in the fault scenario.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  // Field order matches control-register bit positions 7..0.
  typedef struct packed {
    logic       ie;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int               W      = 3,
  parameter int               STAGES = 2,
  parameter logic [W-1:0]     RST    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage[0] <= RST;
    else        stage[0] <= d;

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stage[i] <= RST;
      else        stage[i] <= stage[i-1];
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  input  logic       dbl,
  output logic       tick
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] base, half, cnt;

  always_comb begin
    case (rate)
      2'b00:   base = CNT_W'(2);
      2'b01:   base = CNT_W'(8);
      2'b10:   base = CNT_W'(32);
      default: base = CNT_W'(64);
    endcase
    half = dbl ? (base >> 1) : base;
  end

  assign tick = run && (cnt == half - ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + ONE;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       irq_ack,
  input  logic       sck_in,
  input  logic       mosi_in,
  input  logic       ss_n_in,
  input  logic       miso_in,
  output logic       sck_out,
  output logic       sck_out_en,
  output logic       mosi_out,
  output logic       mosi_out_en,
  output logic       miso_out,
  output logic       miso_out_en
);
  localparam int BITS = 8;
  localparam int EDGES = 2 * BITS;

  ctrl_t      ctrl;
  logic       spif, wcol, dbl, arm;
  logic [7:0] sr, rxbuf, shifted;
  logic       samp, dout, sck_r, busy, s_act;
  logic [$clog2(EDGES)-1:0] ecnt;
  logic [$clog2(BITS)-1:0]  bcnt;
  logic       sck_s, mosi_s, ss_n_s, sck_d;
  logic       tick, is_mst, is_slv;
  logic       lead, trail, lead_s, trail_s, done, mf;
  logic       rx_in, out_bit, bit_in, in_prog, load;
  logic       ctrl_wr, stat_rd, dat_wr, dat_acc;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_in, sck_in, mosi_in}), .q({ss_n_s, sck_s, mosi_s}));

  spi_clkgen #(.CNT_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(ctrl.rate),
    .dbl(dbl), .tick(tick));

  // Decode
  assign ctrl_wr = reg_wr && reg_addr == ADDR_CTRL;
  assign stat_rd = reg_rd && reg_addr == ADDR_STAT;
  assign dat_wr  = reg_wr && reg_addr == ADDR_DATA;
  assign dat_acc = (reg_wr || reg_rd) && reg_addr == ADDR_DATA;

  assign is_mst = ctrl.en && ctrl.master;
  assign is_slv = ctrl.en && !ctrl.master;
  assign mf     = is_mst && !ss_n_s;

  // Edge detection for both roles
  assign lead_s  = is_slv && !ss_n_s && (sck_s != ctrl.cpol) && (sck_d == ctrl.cpol);
  assign trail_s = is_slv && !ss_n_s && (sck_s == ctrl.cpol) && (sck_d != ctrl.cpol);
  assign lead    = is_mst ? (tick && sck_r == ctrl.cpol) : lead_s;
  assign trail   = is_mst ? (tick && sck_r != ctrl.cpol) : trail_s;
  assign done    = is_mst ? (trail && ecnt == '1) : (trail_s && bcnt == '1);

  assign rx_in   = is_mst ? miso_in : mosi_s;
  assign out_bit = ctrl.lsb_first ? sr[0] : sr[7];
  assign bit_in  = ctrl.cpha ? rx_in : samp;
  assign shifted = ctrl.lsb_first ? {bit_in, sr[7:1]} : {sr[6:0], bit_in};
  assign in_prog = busy || s_act;
  assign load    = dat_wr && ctrl.en && !in_prog;

  // Transfer engine
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; s_act <= 1'b0; ecnt <= '0; bcnt <= '0;
    end else if (ctrl_wr || mf) begin
      busy <= 1'b0; s_act <= 1'b0; ecnt <= '0; bcnt <= '0;
    end else if (is_mst) begin
      if (load) begin
        busy <= 1'b1; ecnt <= '0;
      end else if (tick) begin
        ecnt <= ecnt + 1'b1;
        if (done) busy <= 1'b0;
      end
    end else if (ss_n_s) begin
      bcnt <= '0; s_act <= 1'b0;
    end else begin
      if (lead_s) s_act <= 1'b1;
      if (trail_s) begin
        bcnt <= bcnt + 1'b1;
        if (done) s_act <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr <= '0; rxbuf <= '0; samp <= 1'b0; dout <= 1'b0;
      sck_r <= 1'b0; sck_d <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (!busy)     sck_r <= ctrl.cpol;
      else if (tick) sck_r <= ~sck_r;
      if (lead) begin
        samp <= rx_in;
        dout <= out_bit;
      end
      if (load)       sr <= reg_wdata;
      else if (trail) sr <= shifted;
      if (done)       rxbuf <= shifted;
    end

  // Registers and flags
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; dbl <= 1'b0; spif <= 1'b0; wcol <= 1'b0; arm <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata);
      if (mf)      ctrl.master <= 1'b0;
      if (reg_wr && reg_addr == ADDR_STAT) dbl <= reg_wdata[0];
      if (done || mf)                    spif <= 1'b1;
      else if (irq_ack || (dat_acc && arm)) spif <= 1'b0;
      if (dat_wr && ctrl.en && in_prog) wcol <= 1'b1;
      else if (dat_acc && arm)          wcol <= 1'b0;
      if (stat_rd && (spif || wcol)) arm <= 1'b1;
      else if (dat_acc)              arm <= 1'b0;
    end

  always_comb
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl;
      ADDR_STAT: reg_rdata = {spif, wcol, 5'b0, dbl};
      ADDR_DATA: reg_rdata = rxbuf;
      default:   reg_rdata = '0;
    endcase

  assign irq         = spif && ctrl.ie;
  assign sck_out     = busy ? sck_r : ctrl.cpol;
  assign sck_out_en  = is_mst;
  assign mosi_out    = ctrl.cpha ? dout : out_bit;
  assign mosi_out_en = is_mst;
  assign miso_out    = ctrl.cpha ? dout : out_bit;
  assign miso_out_en = is_slv && !ss_n_s;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       irq_ack,
  input logic       busy,
  input logic       tick,
  input logic       done,
  input logic       mf,
  input logic       spif,
  input logic       wcol,
  input logic       sck_out,
  input logic       cpol,
  input logic       en,
  input logic       master,
  input logic       is_mst,
  input logic       is_slv,
  input logic       ss_n_s,
  input logic [2:0] bcnt,
  input logic       s_act
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && reg_addr == 2'd0;

  // R4
  sck_idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_mst) |=> (sck_out == cpol));

  // R5
  sck_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !ctrl_wr && !mf) |=> $stable(sck_out));

  // R6
  ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !done && !mf) |=> !spif);

  // R8
  collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd2 && en && busy) |=> wcol);

  // R9
  mode_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mst && !ss_n_s) |=> (!master && spif));

  // R11
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slv && ss_n_s) |=> (bcnt == 3'd0 && !s_act));
endmodule

bind spi_ctrl spi_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .irq_ack(irq_ack), .busy(busy), .tick(tick), .done(done), .mf(mf),
  .spif(spif), .wcol(wcol), .sck_out(sck_out), .cpol(ctrl.cpol),
  .en(ctrl.en), .master(ctrl.master), .is_mst(is_mst), .is_slv(is_slv),
  .ss_n_s(ss_n_s), .bcnt(bcnt), .s_act(s_act));

// File: tb/test_spi_ctrl.sv
`timescale 1ns/1ps
module test_spi_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, irq_ack = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq, sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1, miso_in = 1'b0;
  logic       sck_out, sck_out_en, mosi_out, mosi_out_en, miso_out, miso_out_en;
  int checks = 0, errors = 0;
  bit finished = 0;

  spi_ctrl i_spi_ctrl (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_lvl(input logic v);
    if (v) @(posedge sck_out); else @(negedge sck_out);
  endtask

  // Bench-side slave attached to the master outputs.
  task automatic dev_model(input logic cpol, cpha, lsb, input logic [7:0] stim,
                           output logic [7:0] got);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      if (!cpha) begin
        miso_in = stim[idx]; wait_lvl(!cpol); #1 got[idx] = mosi_out; wait_lvl(cpol);
      end else begin
        wait_lvl(!cpol); #1 miso_in = stim[idx]; wait_lvl(cpol); #1 got[idx] = mosi_out;
      end
    end
  endtask

  task automatic wait_flag();
    logic [7:0] s;
    int n = 0;
    s = '0;
    while (!s[7] && n < 3000) begin rd(2'd1, s); n++; end
  endtask

  task automatic reset_case();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 pins", {4'b0, irq, sck_out, sck_out_en, miso_out_en}, 8'h00);
  endtask

  task automatic reserved_case();
    logic [7:0] v;
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 reserved status bits", v, 8'h01);
    wr(2'd1, 8'h00);
  endtask

  task automatic master_case(input string tag, input logic cpol, cpha, lsb,
                             input logic [1:0] rate, input logic dbl,
                             input logic [7:0] tx, stim);
    logic [7:0] got, v;
    wr(2'd0, {2'b01, lsb, 1'b1, cpol, cpha, rate});
    wr(2'd1, {7'b0, dbl});
    @(negedge clk); chk({tag, " idle sck"}, {7'b0, sck_out}, {7'b0, cpol});
    fork
      wr(2'd2, tx);
      dev_model(cpol, cpha, lsb, stim, got);
    join
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R6 flag after transfer", v & 8'h80, 8'h80);
    rd(2'd2, v); chk({tag, " received"}, v, stim);
    chk({tag, " sent"}, got, tx);
    chk("R4 sck back to idle", {7'b0, sck_out}, {7'b0, cpol});
  endtask

  task automatic period_case(input logic [1:0] rate, input logic dbl, input int exp);
    realtime t0, t1;
    logic [7:0] v;
    wr(2'd0, {4'b0101, 2'b00, rate});
    wr(2'd1, {7'b0, dbl});
    fork
      wr(2'd2, 8'h00);
      begin @(posedge sck_out); t0 = $realtime; @(negedge sck_out); t1 = $realtime; end
    join
    chk("R5 half period", 8'(int'((t1 - t0) / 5.0)), 8'(exp));
    wait_flag();
    rd(2'd2, v);
  endtask

  task automatic irq_case();
    logic [7:0] got, v;
    wr(2'd0, 8'hD0); wr(2'd1, 8'h00);
    chk("R6 irq low before", {7'b0, irq}, 8'h00);
    fork wr(2'd2, 8'h81); dev_model(1'b0, 1'b0, 1'b0, 8'h18, got); join
    repeat (4) @(negedge clk);
    chk("R6 irq raised", {7'b0, irq}, 8'h01);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; @(negedge clk);
    chk("R6 irq after ack", {7'b0, irq}, 8'h00);
    rd(2'd1, v); chk("R6 flag after ack", v, 8'h00);
    rd(2'd2, v);
  endtask

  task automatic clear_case();
    logic [7:0] got, v;
    wr(2'd0, 8'h50);
    fork wr(2'd2, 8'h77); dev_model(1'b0, 1'b0, 1'b0, 8'hE1, got); join
    repeat (4) @(negedge clk);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 data access alone keeps flag", v, 8'h80);
    rd(2'd2, v); chk("R7 data", v, 8'hE1);
    rd(2'd1, v); chk("R7 sequence clears flag", v, 8'h00);
  endtask

  task automatic wcol_case();
    logic [7:0] got, v;
    wr(2'd0, 8'h53); wr(2'd1, 8'h00);
    fork
      begin wr(2'd2, 8'hA5); repeat (20) @(negedge clk); wr(2'd2, 8'h5A); end
      dev_model(1'b0, 1'b0, 1'b0, 8'h00, got);
    join
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R8 collision and done flags", v, 8'hC0);
    chk("R8 byte unchanged", got, 8'hA5);
    rd(2'd2, v);
    rd(2'd1, v); chk("R7 both flags cleared", v, 8'h00);
  endtask

  task automatic fault_case();
    logic [7:0] v;
    wr(2'd0, 8'h50);
    ss_n_in = 1'b0; repeat (6) @(negedge clk);
    rd(2'd0, v); chk("R9 master bit cleared", v, 8'h40);
    rd(2'd1, v); chk("R9 flag set", v, 8'h80);
    ss_n_in = 1'b1; repeat (4) @(negedge clk);
    rd(2'd2, v);
  endtask

  task automatic slave_run(input string tag, input logic cpol, cpha, lsb,
                           input logic [7:0] mtx, exp_miso);
    logic [7:0] got, v;
    got = '0;
    ss_n_in = 1'b0; repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi_in = mtx[idx]; repeat (8) @(negedge clk);
        sck_in = !cpol; got[idx] = miso_out; repeat (8) @(negedge clk); sck_in = cpol;
      end else begin
        repeat (8) @(negedge clk); sck_in = !cpol; mosi_in = mtx[idx];
        repeat (8) @(negedge clk); sck_in = cpol; got[idx] = miso_out;
      end
    end
    repeat (8) @(negedge clk); ss_n_in = 1'b1; repeat (6) @(negedge clk);
    rd(2'd1, v); chk({tag, " flag"}, v, 8'h80);
    rd(2'd2, v); chk({tag, " received"}, v, mtx);
    chk({tag, " sent"}, got, exp_miso);
  endtask

  task automatic slave_case(input string tag, input logic cpol, cpha, lsb,
                            input logic [7:0] load, mtx);
    sck_in = cpol;
    wr(2'd0, {2'b01, lsb, 1'b0, cpol, cpha, 2'b00});
    wr(2'd2, load);
    slave_run(tag, cpol, cpha, lsb, mtx, load);
  endtask

  task automatic ignore_case();
    logic [7:0] v;
    sck_in = 1'b0;
    wr(2'd0, 8'h40); wr(2'd2, 8'h96);
    for (int i = 0; i < 16; i++) begin
      repeat (8) @(negedge clk); sck_in = ~sck_in; mosi_in = ~mosi_in;
    end
    repeat (6) @(negedge clk);
    rd(2'd1, v); chk("R11 no flag while deselected", v, 8'h00);
    slave_run("R11 nothing shifted", 1'b0, 1'b0, 1'b0, 8'h5B, 8'h96);
  endtask

  task automatic disabled_case();
    logic [7:0] v;
    sck_in = 1'b0;
    wr(2'd0, 8'h40); wr(2'd2, 8'h3C);
    wr(2'd0, 8'h00); wr(2'd2, 8'hC3);
    rd(2'd1, v); chk("R12 no collision when disabled", v, 8'h00);
    wr(2'd0, 8'h40);
    slave_run("R12 write ignored", 1'b0, 1'b0, 1'b0, 8'h24, 8'h3C);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    reset_case();
    reserved_case();
    master_case("R3 msb-first", 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'hA5, 8'h3C);
    master_case("R3 lsb-first", 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 8'hC1, 8'h2B);
    master_case("R4 mode1", 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 8'h96, 8'h69);
    master_case("R4 mode2", 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 8'h0F, 8'hF0);
    master_case("R4 mode3", 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 8'h72, 8'h8D);
    period_case(2'b01, 1'b0, 8);
    period_case(2'b00, 1'b1, 1);
    period_case(2'b10, 1'b1, 16);
    period_case(2'b11, 1'b0, 64);
    irq_case();
    clear_case();
    wcol_case();
    fault_case();
    slave_case("R10 slave mode0", 1'b0, 1'b0, 1'b0, 8'hB4, 8'h4D);
    slave_case("R10 slave mode3 lsb", 1'b1, 1'b1, 1'b1, 8'h1E, 8'hE7);
    slave_case("R10 slave mode1", 1'b0, 1'b1, 1'b0, 8'h6A, 8'h95);
    ignore_case();
    disabled_case();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule